// File: doc/BRIEF.md
# Depth expansion token controller

This block is the control section of one slice in a ring of FIFO slices. Chained together, the slices act as a single buffer whose depth is the sum of their depths. Each slice keeps a write token and a read token. Only the slice that holds the write token accepts writes, and only the slice that holds the read token serves reads. A slice drives its local memory enables and addresses, and it keeps count of the words stored in its own storage. When it has accessed its last physical location, it hands the matching token to the next slice with a one-cycle low pulse on its expansion output. The expansion output of each slice feeds the expansion input of the next slice, and the last slice feeds the first, so the slices form a closed ring.

The slice captures its mode in the first clock cycle after reset:

- **Standalone:** selected when the expansion input is held low and the first-load input is high. The slice keeps both tokens permanently. It provides a half-full indication and supports retransmit.
- **Depth:** selected otherwise. The slice whose first-load input is low starts with both tokens. The other slices start with none.

Per-slice full and empty flags are reported only by the slice that holds the relevant token. An OR across all slices therefore gives the composite flag. The data storage and the data bus are outside this block.

Top module: `xdepth_ctl`

## Requirements
- R1: In the first clock after reset release, the slice captures its mode: standalone if expansion-in is low and first-load is high, depth otherwise. No access happens in that cycle.
- R2: In depth mode, the slice with first-load low starts owning both tokens. Every other slice starts owning neither token. After configuration, the empty flag of the first slice reads 1 and the empty flags of the others read 0.
- R3: Only the write-token holder asserts the write enable, for a write strobe while it is not full. Write addresses run 0, 1, …, DEPTH-1.
- R4: Only the read-token holder asserts the read enable, for a read strobe while it is not empty. Read addresses run 0, 1, …, DEPTH-1.
- R5: In depth mode, a write to address DEPTH-1 gives up the write token and wraps the write address to 0. In the next cycle, expansion-out is low for exactly one cycle.
- R6: In depth mode, a read of address DEPTH-1 does the same for the read token and the read address.
- R7: A slice in depth mode that sees expansion-in low takes the write token if the write strobe is high. Otherwise, it takes the read token if the read strobe is high. No slice performs an access during that handoff cycle.
- R8: A write to a slice holding DEPTH words is ignored. The full flag is 1 only on the write-token holder, and only while it holds DEPTH words.
- R9: A read from a slice holding no words is ignored. The empty flag is 1 only on the read-token holder, and only while it holds no words.
- R10: In standalone mode, both tokens stay local, both addresses wrap from DEPTH-1 to 0, and expansion-out stays high.
- R11: The half-full output is 1 in standalone mode while the word count exceeds DEPTH/2. It is always 0 in depth mode.
- R12: In standalone mode, retransmit sets the read address to 0. It sets the count to DEPTH if the write address has ever wrapped, and to the write address otherwise. Both strobes are ignored in that cycle. In depth mode, retransmit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| first_n_i | input | 1 | First-load select, active low |
| xin_n_i | input | 1 | Expansion input from the previous slice, active low pulse |
| xout_n_o | output | 1 | Expansion output to the next slice, registered, active low |
| wr_strobe_i | input | 1 | Shared write strobe |
| rd_strobe_i | input | 1 | Shared read strobe |
| retx_i | input | 1 | Retransmit request (standalone only) |
| wr_en_o | output | 1 | Local memory write enable |
| wr_addr_o | output | AW | Local write address |
| rd_en_o | output | 1 | Local memory read enable |
| rd_addr_o | output | AW | Local read address |
| full_o | output | 1 | Slice full flag, gated by write-token ownership |
| empty_o | output | 1 | Slice empty flag, gated by read-token ownership |
| half_o | output | 1 | More than half full (standalone only) |

## Verification
The hardest states to reach are the ring boundaries. The first is a full ring, where the write token arrives at a slice whose words have not yet been read. The second is an empty ring, where the read token has just caught up with the writer. Handoff cycles in which the strobes decide which token moves are also hard to reach. The stimulus alternates long fill-biased and drain-biased phases of random strobes over a three-slice ring of depth 4, so that the total capacity is crossed many times. Whenever a last-location access occurs, the stimulus holds the matching strobe through the handoff cycle. Retransmit and the full and empty corners of a standalone slice are driven directly first, then at random.

// File: rtl/xdepth_pkg.sv
package xdepth_pkg;
  typedef enum logic {
    TOK_WR = 1'b0,
    TOK_RD = 1'b1
  } tok_kind_e;
endpackage

// File: rtl/xdepth_token.sv
module xdepth_token #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          init_own_i,
  input  logic          solo_i,
  input  logic          strobe_i,
  input  logic          block_i,
  input  logic          claim_i,
  input  logic          rewind_i,
  output logic          own_o,
  output logic          fire_o,
  output logic          last_o,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          own_q;
  logic [AW-1:0] addr_q;
  logic          at_last;

  assign at_last = (addr_q == LAST);
  assign fire_o  = own_q && strobe_i && !block_i;
  assign last_o  = fire_o && at_last;
  assign own_o   = own_q;
  assign addr_o  = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q  <= 1'b0;
      addr_q <= '0;
    end else if (load_i) begin
      own_q  <= init_own_i;
      addr_q <= '0;
    end else begin
      if (rewind_i)    addr_q <= '0;
      else if (fire_o) addr_q <= at_last ? '0 : addr_q + 1'b1;
      // handoff drops the token; a claim takes it
      if (last_o && !solo_i) own_q <= 1'b0;
      else if (claim_i)      own_q <= 1'b1;
    end
  end

  // R5 / R6: address wraps after the last location
  p_addr_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !rewind_i) |=> (addr_q == '0));

  // R5 / R6: token released after handoff in depth mode
  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !solo_i) |=> !own_q);

  // R10: standalone never loses a token it holds
  p_solo_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (solo_i && own_q && !load_i) |=> own_q);
endmodule

// File: rtl/xdepth_level.sv
module xdepth_level #(
  parameter int DEPTH = 512,
  parameter int AW    = 9,
  parameter int CW    = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          solo_i,
  input  logic          inc_i,
  input  logic          dec_i,
  input  logic          wr_wrap_i,
  input  logic          rewind_i,
  input  logic [AW-1:0] wr_addr_i,
  output logic          full_o,
  output logic          empty_o,
  output logic          half_o
);
  logic [CW-1:0] cnt_q;
  logic          wrapped_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign half_o  = solo_i && (cnt_q > CW'(DEPTH / 2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      wrapped_q <= 1'b0;
    end else if (load_i) begin
      cnt_q     <= '0;
      wrapped_q <= 1'b0;
    end else begin
      wrapped_q <= wrapped_q | wr_wrap_i;
      if (rewind_i) cnt_q <= wrapped_q ? CW'(DEPTH) : CW'(wr_addr_i);
      else          cnt_q <= cnt_q + CW'(inc_i) - CW'(dec_i);
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  p_full_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !dec_i && !rewind_i && !load_i) |=> full_o);

  p_empty_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !inc_i && !rewind_i) |=> empty_o);
endmodule

// File: rtl/xdepth_ctl.sv
module xdepth_ctl
  import xdepth_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          first_n_i,
  input  logic          xin_n_i,
  output logic          xout_n_o,
  input  logic          wr_strobe_i,
  input  logic          rd_strobe_i,
  input  logic          retx_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          half_o
);
  logic cfg_q, solo_q, xout_q;
  logic load, init_solo, init_own, retx_eff, pulse_in;
  logic loc_full, loc_empty;
  logic [1:0] strobe, block, claim, rewind, own, fire, last;
  logic [AW-1:0] addr [2];

  assign load      = !cfg_q;
  assign init_solo = !xin_n_i && first_n_i;
  assign init_own  = init_solo || !first_n_i;
  assign retx_eff  = retx_i && solo_q && cfg_q;
  assign pulse_in  = cfg_q && !solo_q && !xin_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= 1'b0;
      solo_q <= 1'b0;
    end else if (!cfg_q) begin
      cfg_q  <= 1'b1;
      solo_q <= init_solo;
    end
  end

  assign strobe[TOK_WR] = wr_strobe_i && cfg_q && !retx_eff;
  assign strobe[TOK_RD] = rd_strobe_i && cfg_q && !retx_eff;
  assign block[TOK_WR]  = loc_full;
  assign block[TOK_RD]  = loc_empty;
  // token kind is decided by the strobe seen with the pulse
  assign claim[TOK_WR]  = pulse_in && wr_strobe_i;
  assign claim[TOK_RD]  = pulse_in && !wr_strobe_i && rd_strobe_i;
  assign rewind[TOK_WR] = 1'b0;
  assign rewind[TOK_RD] = retx_eff;

  for (genvar t = 0; t < 2; t++) begin : g_tok
    xdepth_token #(.DEPTH(DEPTH), .AW(AW)) u_tok (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load),
      .init_own_i(init_own),
      .solo_i    (solo_q),
      .strobe_i  (strobe[t]),
      .block_i   (block[t]),
      .claim_i   (claim[t]),
      .rewind_i  (rewind[t]),
      .own_o     (own[t]),
      .fire_o    (fire[t]),
      .last_o    (last[t]),
      .addr_o    (addr[t])
    );
  end

  xdepth_level #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_level (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .solo_i   (solo_q),
    .inc_i    (fire[TOK_WR]),
    .dec_i    (fire[TOK_RD]),
    .wr_wrap_i(last[TOK_WR]),
    .rewind_i (retx_eff),
    .wr_addr_i(addr[TOK_WR]),
    .full_o   (loc_full),
    .empty_o  (loc_empty),
    .half_o   (half_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) xout_q <= 1'b1;
    else         xout_q <= !(!solo_q && (last[TOK_WR] || last[TOK_RD]));
  end

  assign xout_n_o  = xout_q;
  assign wr_en_o   = fire[TOK_WR];
  assign wr_addr_o = addr[TOK_WR];
  assign rd_en_o   = fire[TOK_RD];
  assign rd_addr_o = addr[TOK_RD];
  assign full_o    = own[TOK_WR] && loc_full;
  assign empty_o   = own[TOK_RD] && loc_empty;

  p_pulse_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xout_q |=> xout_q);

  p_solo_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    solo_q |-> xout_q);

  p_no_access_in_cfg_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q |-> !(wr_en_o || rd_en_o));

  p_half_depth_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q && !solo_q) |-> !half_o);
endmodule

// File: tb/xdepth_ctl_test.sv
`timescale 1ns/1ps
module xdepth_ctl_test;
  localparam int N = 3, RD = 4, SD = 8, RAW = 2, SAW = 3, CAP = N * RD;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic ws = 0, rs = 0, rt = 0;
  logic [N-1:0] xo, wen, ren, fl, em, hf;
  logic [RAW-1:0] wa [N];
  logic [RAW-1:0] ra [N];

  for (genvar k = 0; k < N; k++) begin : g_ring
    xdepth_ctl #(.DEPTH(RD)) u_slice (
      .clk_i(clk), .rst_ni(rst_n), .first_n_i(1'(k != 0)),
      .xin_n_i(xo[(k + N - 1) % N]), .xout_n_o(xo[k]),
      .wr_strobe_i(ws), .rd_strobe_i(rs), .retx_i(rt),
      .wr_en_o(wen[k]), .wr_addr_o(wa[k]), .rd_en_o(ren[k]), .rd_addr_o(ra[k]),
      .full_o(fl[k]), .empty_o(em[k]), .half_o(hf[k]));
  end

  logic sws = 0, srs = 0, srt = 0;
  logic s_xo, s_wen, s_ren, s_fl, s_em, s_hf;
  logic [SAW-1:0] s_wa, s_ra;

  xdepth_ctl #(.DEPTH(SD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .first_n_i(1'b1), .xin_n_i(1'b0), .xout_n_o(s_xo),
    .wr_strobe_i(sws), .rd_strobe_i(srs), .retx_i(srt),
    .wr_en_o(s_wen), .wr_addr_o(s_wa), .rd_en_o(s_ren), .rd_addr_o(s_ra),
    .full_o(s_fl), .empty_o(s_em), .half_o(s_hf));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int gw = 0, gr = 0, cnt = 0, pend = 0, pslot = 0;
  int sw = 0, sr = 0, scnt = 0;
  bit swrap = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle(input bit wq, input bit rq, input bit tq,
                       input bit sa, input bit sb, input bit sc);
    bit w, r, wok, rok, swok, srok;
    int npend, nps;
    @(negedge clk);
    if (pend == 1)      begin w = 1; r = 0; end
    else if (pend == 2) begin w = 0; r = 1; end
    else begin
      w = wq; r = rq;
      if (w && cnt < CAP && r && cnt > 0 && gw % RD == RD - 1 && gr % RD == RD - 1) r = 0;
    end
    wok  = (pend == 0) && w && cnt < CAP;
    rok  = (pend == 0) && r && cnt > 0;
    swok = !sc && sa && scnt < SD;
    srok = !sc && sb && scnt > 0;
    ws = w; rs = r; rt = tq; sws = sa; srs = sb; srt = sc;
    #1;
    for (int k = 0; k < N; k++) begin
      chk("R3 ring write enable", wen[k], int'(wok && gw / RD == k));
      if (wok && gw / RD == k) chk("R3 ring write address", wa[k], gw % RD);
      chk("R4 ring read enable", ren[k], int'(rok && gr / RD == k));
      if (rok && gr / RD == k) chk("R4 ring read address", ra[k], gr % RD);
      if (pend == 2) chk("R6 read handoff pulse", xo[k], int'(pslot != k));
      else           chk("R5 write handoff pulse", xo[k], int'(!(pend == 1 && pslot == k)));
      chk("R11 no half flag in depth", hf[k], 0);
    end
    if (pend != 0) chk("R7 no access in handoff cycle", int'(|wen) + int'(|ren), 0);
    else begin
      chk("R8 composite full", int'(|fl), int'(cnt == CAP));
      chk("R9 composite empty", int'(|em), int'(cnt == 0));
    end
    chk(sc ? "R12 solo write enable" : "R10 solo write enable", s_wen, int'(swok));
    if (swok) chk("R10 solo write address", s_wa, sw);
    chk(sc ? "R12 solo read enable" : "R10 solo read enable", s_ren, int'(srok));
    if (srok) chk("R10 solo read address", s_ra, sr);
    chk("R8 solo full", s_fl, int'(scnt == SD));
    chk("R9 solo empty", s_em, int'(scnt == 0));
    chk("R11 solo half", s_hf, int'(scnt > SD / 2));
    chk("R10 solo expansion quiet", s_xo, 1);
    npend = 0; nps = 0;
    if (wok) begin
      if (gw % RD == RD - 1) begin npend = 1; nps = gw / RD; end
      gw = (gw + 1) % CAP; cnt++;
    end
    if (rok) begin
      if (gr % RD == RD - 1) begin npend = 2; nps = gr / RD; end
      gr = (gr + 1) % CAP; cnt--;
    end
    pend = npend; pslot = nps;
    if (sc) begin
      sr = 0; scnt = swrap ? SD : sw;
    end else begin
      if (swok) begin
        if (sw == SD - 1) swrap = 1;
        sw = (sw + 1) % SD; scnt++;
      end
      if (srok) begin sr = (sr + 1) % SD; scnt--; end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1 reset expansion out", int'(&xo) + int'(s_xo), 2);
    chk("R1 reset enables", int'(|wen) + int'(|ren) + int'(s_wen) + int'(s_ren), 0);
    rst_n = 1'b1;
    // configuration cycle: strobes present but must be ignored
    ws = 1; rs = 1; sws = 1; srs = 1;
    #1;
    chk("R1 no access in config cycle", int'(|wen) + int'(|ren) + int'(s_wen), 0);
    @(negedge clk);
    ws = 0; rs = 0; sws = 0; srs = 0;
    #1;
    chk("R2 initial read ownership", int'(em), 1);
    chk("R1 standalone captured", s_em, 1);
    // directed: fill solo past full, retransmit, drain past empty
    for (int i = 0; i < SD + 1; i++) cycle(1, 0, 0, 1, 0, 0);
    cycle(0, 0, 1, 0, 0, 1);
    for (int i = 0; i < 3; i++) cycle(0, 1, 0, 0, 1, 0);
    cycle(0, 0, 0, 1, 1, 1);
    for (int i = 0; i < SD + 2; i++) cycle(0, 1, 0, 0, 1, 0);
    // random phases
    for (int i = 0; i < 3000; i++) begin
      bit fill;
      fill = ((i / 48) % 2) == 0;
      cycle(fill ? ($urandom % 4 != 0) : ($urandom % 4 == 0),
            fill ? ($urandom % 4 == 0) : ($urandom % 4 != 0),
            $urandom % 50 == 0,
            fill ? ($urandom % 3 != 0) : ($urandom % 3 == 0),
            fill ? ($urandom % 3 == 0) : ($urandom % 3 != 0),
            $urandom % 60 == 0);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule